// File: doc/BRIEF.md
# IOMMU Control Register Interface

This block is the memory-mapped register front end of an I/O address translation unit. It holds two 64-bit registers: a control word and a translation-table base address. It also answers at a flush slot, which accepts writes with no effect and reads back zero. The stored values go straight out on two buses to the translation engine.

Software can reach each register either with one 64-bit access or with two 32-bit accesses. Word order is big-endian. The 32-bit access at a register's own offset reaches its upper half, and the access four bytes above reaches its lower half. A half-word write merges into the register and leaves the other half as it was. Reads are registered, so the data appears one cycle after the read strobe. Reset clears everything to zero, and a zero control word means translation is off.

Top module: `iommu_regif`

## Requirements
- R1: While reset is asserted, and right after it is released, the control output, the base output and the read data are all zero.
- R2: A 64-bit write (size64=1) at offset 0x00 (control) or 0x08 (base) replaces the whole register with wdata. A 64-bit read at those offsets returns the whole register.
- R3: A 32-bit write (size64=0) at offset 0x00 or 0x08 loads wdata[31:0] into bits 63:32 of that register and leaves bits 31:0 unchanged.
- R4: A write of either size at offset 0x04 (control) or 0x0C (base) loads wdata[31:0] into bits 31:0 of that register and leaves bits 63:32 unchanged.
- R5: A 32-bit read at offset 0x00 or 0x08 returns bits 63:32 of the register on rdata[31:0], with rdata[63:32] zero.
- R6: A read of either size at offset 0x04 or 0x0C returns bits 31:0 of the register on rdata[31:0], with rdata[63:32] zero.
- R7: Writes at offsets 0x10 and 0x14 (flush) change neither register, and reads there return zero.
- R8: Any other offset is ignored on write and reads as zero. This covers offsets that are not a multiple of 4 and offsets at or above 0x18.
- R9: Read data is registered. It takes its new value at the first rising edge where rd_en is high and holds that value while rd_en is low.
- R10: A register write shows on ctrl_out or base_out from the first rising edge after the write strobe.
- R11: A read and a write to the same offset in the same cycle return the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| size64 | input | 1 | Access size: 1 = 64-bit, 0 = 32-bit |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rdata | output | 64 | Registered read data |
| ctrl_out | output | 64 | Current control register value |
| base_out | output | 64 | Current table-base register value |

## Verification
A faulty half-word merge in a register slice shows on ctrl_out or base_out one edge after the write. The fault is either a foreign half that changed or a written half that was lost, and the bench compares both halves at that point. A decode slip shows in two ways: a flush or out-of-range write lands in a live register, which the output buses show one cycle later, or a read that should give zero returns data. The bench first primes rdata with a non-zero value, so a zero read one edge after the strobe proves the decode rather than an idle bus. A broken read-hold path shows as rdata moving during idle cycles.

// File: rtl/iommu_regif_pkg.sv
package iommu_regif_pkg;

    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;
    localparam int NUM_REGS = 2;                 // slot 0 control, slot 1 base
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int SLOT_SHIFT = 3;               // 8-byte register slots
    localparam int LANE_BIT   = 2;               // selects low half in slot

    typedef enum logic [1:0] {
        HALF_FULL = 2'd0,
        HALF_UP   = 2'd1,
        HALF_LO   = 2'd2
    } half_e;

    typedef struct packed {
        logic             hit;    // addresses a live register
        logic             flush;  // addresses the flush slot
        logic [IDX_W-1:0] idx;
        half_e            half;
    } sel_t;

endpackage

// File: rtl/iommu_regif_decode.sv
module iommu_regif_decode
    import iommu_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size64,
    output sel_t              sel
);

    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    logic [SLOT_W-1:0] slot;
    logic              aligned;

    always_comb begin
        slot    = addr[ADDR_W-1:SLOT_SHIFT];
        aligned = (addr[1:0] == 2'b00);

        sel       = '0;
        sel.half  = HALF_FULL;

        if (aligned) begin
            if (slot < SLOT_W'(NUM_REGS)) begin
                sel.hit = 1'b1;
                sel.idx = IDX_W'(slot);
            end else if (slot == SLOT_W'(NUM_REGS)) begin
                sel.flush = 1'b1;
            end
        end

        // lane 1 always reaches the low half; lane 0 reaches the whole
        // register for 64-bit accesses and the upper half otherwise
        if (addr[LANE_BIT]) begin
            sel.half = HALF_LO;
        end else if (size64) begin
            sel.half = HALF_FULL;
        end else begin
            sel.half = HALF_UP;
        end
    end

endmodule

// File: rtl/iommu_regif_reg.sv
module iommu_regif_reg
    import iommu_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  half_e             half,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            unique case (half)
                HALF_FULL: st_d.val = wdata;
                HALF_UP:   st_d.val[DATA_W-1:HALF_W] = wdata[HALF_W-1:0];
                HALF_LO:   st_d.val[HALF_W-1:0]      = wdata[HALF_W-1:0];
                default:   st_d.val = st_q.val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    // R3
    upper_merge_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && half == HALF_UP) |=> (q[HALF_W-1:0] == $past(q[HALF_W-1:0])) &&
                                   (q[DATA_W-1:HALF_W] == $past(wdata[HALF_W-1:0])));

    // R4
    lower_merge_keeps_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && half == HALF_LO) |=> (q[DATA_W-1:HALF_W] == $past(q[DATA_W-1:HALF_W])) &&
                                   (q[HALF_W-1:0] == $past(wdata[HALF_W-1:0])));

    // R2
    full_write_loads_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && half == HALF_FULL) |=> (q == $past(wdata)));

    // R10
    idle_reg_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/iommu_regif_rdmux.sv
module iommu_regif_rdmux
    import iommu_regif_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  sel_t                           sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]              rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t               st_d, st_q;
    logic [DATA_W-1:0] pick;
    logic [DATA_W-1:0] shaped;

    always_comb begin
        pick   = regs[sel.idx];
        shaped = '0;
        if (sel.hit) begin
            unique case (sel.half)
                HALF_FULL: shaped = pick;
                HALF_UP:   shaped = {{HALF_W{1'b0}}, pick[DATA_W-1:HALF_W]};
                HALF_LO:   shaped = {{HALF_W{1'b0}}, pick[HALF_W-1:0]};
                default:   shaped = '0;
            endcase
        end

        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = shaped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R7 R8
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel.hit) |=> (rdata == '0));

    // R5 R6
    half_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel.half != HALF_FULL) |=> (rdata[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/iommu_regif.sv
module iommu_regif
    import iommu_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              size64,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    output logic [63:0]       ctrl_out,
    output logic [63:0]       base_out
);

    localparam int CTRL_IDX = 0;
    localparam int BASE_IDX = 1;

    sel_t                            sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    iommu_regif_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr   (addr),
        .size64 (size64),
        .sel    (sel)
    );

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic we_i;
        assign we_i = wr_en && sel.hit && (sel.idx == IDX_W'(gi));

        iommu_regif_reg reg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_i),
            .half  (sel.half),
            .wdata (wdata),
            .q     (regs[gi])
        );
    end

    iommu_regif_rdmux rdmux_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .sel   (sel),
        .regs  (regs),
        .rdata (rdata)
    );

    assign ctrl_out = regs[CTRL_IDX];
    assign base_out = regs[BASE_IDX];

    // R7 R8
    miss_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel.hit) |=> ($stable(ctrl_out) && $stable(base_out)));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl_out == '0 && base_out == '0 && rdata == '0));

    // R11
    read_sees_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && sel.hit && sel.half == HALF_FULL && sel.idx == IDX_W'(CTRL_IDX))
            |=> (rdata == $past(ctrl_out)));

endmodule

// File: tb/iommu_regif_tb_top.sv
`timescale 1ns/1ps
module iommu_regif_tb_top;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en, rd_en, size64;
    logic [ADDR_W-1:0] addr;
    logic [63:0]       wdata;
    logic [63:0]       rdata, ctrl_out, base_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    iommu_regif #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .size64(size64), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ctrl_out(ctrl_out), .base_out(base_out)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %016h expected %016h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0; size64 = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic s64, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; size64 = s64; addr = a; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic s64, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; size64 = s64; addr = a;
        @(negedge clk);
        idle();
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; idle();
        repeat (2) @(negedge clk);
        check("R1", "ctrl in reset", ctrl_out, 64'h0);
        check("R1", "base in reset", base_out, 64'h0);
        check("R1", "rdata in reset", rdata, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ctrl after release", ctrl_out, 64'h0);
        check("R1", "base after release", base_out, 64'h0);
    endtask

    task automatic t_full_access();
        logic [63:0] d;
        wr(8'h00, 1'b1, 64'h0123_4567_89AB_CDEF);
        check("R10", "ctrl visible after write", ctrl_out, 64'h0123_4567_89AB_CDEF);
        check("R2", "base untouched by ctrl write", base_out, 64'h0);
        rd(8'h00, 1'b1, d);
        check("R2", "64-bit ctrl read", d, 64'h0123_4567_89AB_CDEF);
        wr(8'h08, 1'b1, 64'hFEDC_BA98_7654_3210);
        check("R10", "base visible after write", base_out, 64'hFEDC_BA98_7654_3210);
        rd(8'h08, 1'b1, d);
        check("R2", "64-bit base read", d, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic t_half_access();
        logic [63:0] d;
        wr(8'h00, 1'b0, 64'hFFFF_FFFF_DEAD_BEEF);
        check("R3", "ctrl upper merge", ctrl_out, 64'hDEAD_BEEF_89AB_CDEF);
        rd(8'h00, 1'b0, d);
        check("R5", "ctrl upper read", d, 64'h0000_0000_DEAD_BEEF);
        rd(8'h04, 1'b0, d);
        check("R6", "ctrl lower read", d, 64'h0000_0000_89AB_CDEF);
        wr(8'h0C, 1'b0, 64'hAAAA_AAAA_1122_3344);
        check("R4", "base lower merge", base_out, 64'hFEDC_BA98_1122_3344);
        wr(8'h08, 1'b0, 64'h0000_0000_5566_7788);
        check("R3", "base upper merge", base_out, 64'h5566_7788_1122_3344);
        wr(8'h04, 1'b1, 64'h9999_9999_0000_0001);
        check("R4", "64-bit write at +4 merges low", ctrl_out, 64'hDEAD_BEEF_0000_0001);
        rd(8'h0C, 1'b1, d);
        check("R6", "64-bit read at +4 gives low", d, 64'h0000_0000_1122_3344);
        rd(8'h08, 1'b1, d);
        check("R2", "base whole after merges", d, 64'h5566_7788_1122_3344);
    endtask

    task automatic t_flush_and_miss();
        logic [63:0] d;
        logic [63:0] c0, b0;
        c0 = ctrl_out; b0 = base_out;
        wr(8'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(8'h14, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7", "ctrl after flush writes", ctrl_out, c0);
        check("R7", "base after flush writes", base_out, b0);
        rd(8'h00, 1'b1, d);                          // prime non-zero
        rd(8'h10, 1'b1, d);
        check("R7", "flush read 0x10", d, 64'h0);
        rd(8'h08, 1'b1, d);
        rd(8'h14, 1'b0, d);
        check("R7", "flush read 0x14", d, 64'h0);
        wr(8'h18, 1'b1, 64'h1);
        wr(8'h02, 1'b0, 64'h2);
        wr(8'h09, 1'b1, 64'h3);
        wr(8'hF8, 1'b1, 64'h4);
        check("R8", "ctrl after stray writes", ctrl_out, c0);
        check("R8", "base after stray writes", base_out, b0);
        rd(8'h00, 1'b1, d);
        rd(8'h1C, 1'b0, d);
        check("R8", "read 0x1C", d, 64'h0);
        rd(8'h00, 1'b1, d);
        rd(8'h01, 1'b1, d);
        check("R8", "read unaligned 0x01", d, 64'h0);
    endtask

    task automatic t_latency_hold();
        logic [63:0] d;
        rd(8'h00, 1'b1, d);
        check("R9", "read after one edge", d, ctrl_out);
        wr(8'h00, 1'b1, 64'h1111_2222_3333_4444);
        repeat (3) @(negedge clk);
        check("R9", "rdata held through write and idle", rdata, d);
    endtask

    task automatic t_same_cycle();
        logic [63:0] old;
        old = ctrl_out;
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; size64 = 1'b1; addr = 8'h00;
        wdata = 64'hCAFE_F00D_0BAD_BEEF;
        @(negedge clk);
        idle();
        check("R11", "read returns pre-write value", rdata, old);
        check("R11", "write still lands", ctrl_out, 64'hCAFE_F00D_0BAD_BEEF);
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        do_reset();
        t_full_access();
        t_half_access();
        t_flush_and_miss();
        t_latency_hold();
        t_same_cycle();
        do_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule